// File: doc/BRIEF.md
# Mode-Selectable Synchronous Clock Divider Tree

This block takes one fast master clock and derives five related clock levels from it: a processor clock, a half-rate processor clock, a fixed 66 MHz clock, a 33 MHz bus clock and an interrupt-controller clock at half the bus rate. A speed strap picks the master frequency plan. With the strap high the master runs at 266 MHz and the branches divide by 2, 4, 4, 8 and 16. With the strap low the master runs at 200 MHz and the branches divide by 2, 4, 3, 6 and 12. The divide-by-3 branch adds a falling-edge stage so that it keeps a 50% duty cycle.

Every branch is decoded from a single frame counter. Its wrap length is a common multiple of all ratios, so each branch rises on the same master edge at the start of every frame. Two select pins, together with the speed strap, choose one of four operating states: all outputs disabled, test mode, normal with the 48 MHz path disabled, or normal with everything enabled. In test mode the master input carries an external test clock. The reference output then passes that clock through, and the 48 MHz output carries the master clock divided by 2. In the other states the reference and 48 MHz outputs pass their own inputs through. The strap and select pins are resynchronised, and a new state is adopted only at a frame boundary, where the counter also restarts.

Top module: `clk_tree_div`

## Requirements
- R1: With the active code {spd_sel_i, sel_i[1], sel_i[0]} equal to 3'b111 or 3'b110, the outputs cpu_o, cpu_half_o, fix66_o, bus_o and irq_o toggle with periods of 2, 4, 4, 8 and 16 master cycles.
- R2: With the active code 3'b011 or 3'b010, those five outputs have periods of 2, 4, 3, 6 and 12 master cycles.
- R3: In the period-3 state, fix66_o is high for exactly 3 of every 6 master half-cycles. It rises on a master rising edge.
- R4: All five branch outputs rise together at the start of each frame. A rise of bus_o always coincides with a rise of fix66_o. A rise of irq_o or of cpu_half_o always coincides with a rise of cpu_o.
- R5: Code 3'b000 and the reserved codes 3'b001 and 3'b101 drive every bit of out_en_o low.
- R6: Code 3'b100 is test mode. The branch periods are 2, 4, 4, 8 and 16, ref_o follows clk_i, usb_o equals cpu_o, and out_en_o is 7'h7F.
- R7: Codes x10 give out_en_o = 7'h3F, and codes x11 give 7'h7F. Bit order in out_en_o is cpu 0, half 1, 66 MHz 2, bus 3, interrupt 4, reference 5, 48 MHz 6. Outside test mode, ref_o equals ref_i and usb_o equals usb_i.
- R8: A code change reaches the active state no sooner than 3 master edges after it is applied and no later than one frame after that. When it takes effect, all five branch outputs are at the start of their high phase.
- R9: Synchronous reset puts the block in the disabled state, with out_en_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, or the test clock in test mode |
| rst_i | input | 1 | Synchronous reset, active high |
| spd_sel_i | input | 1 | Speed strap: 1 selects the 266 MHz plan, 0 the 200 MHz plan |
| sel_i | input | 2 | Operating-state select pins |
| ref_i | input | 1 | Reference oscillator clock, passed through outside test mode |
| usb_i | input | 1 | 48 MHz source, passed through outside test mode |
| cpu_o | output | 1 | Processor clock level |
| cpu_half_o | output | 1 | Half-rate processor clock level |
| fix66_o | output | 1 | Fixed 66 MHz clock level |
| bus_o | output | 1 | 33 MHz bus clock level |
| irq_o | output | 1 | Interrupt-controller clock level |
| ref_o | output | 1 | Reference clock output |
| usb_o | output | 1 | 48 MHz clock output |
| out_en_o | output | 7 | Per-output drive enables for the pad ring |

## Verification
The assertions assume that the select inputs stay put for long enough to be adopted, and that reset is held over the first edges so the frame counter starts inside its range. They also assume the master clock never stops in the middle of a frame. The bench applies each new code and then leaves it alone for more than two full frames. It holds reset for several cycles at start-up. It draws the codes from the eight legal 3-bit values with a fixed-seed generator, and it adds a directed disabled-to-enabled switch to measure the adoption latency.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

   localparam int NUM_BR  = 5;
   localparam int BR_CPU  = 0;
   localparam int BR_HALF = 1;
   localparam int BR_F66  = 2;
   localparam int BR_BUS  = 3;
   localparam int BR_IRQ  = 4;
   localparam int OE_REF  = 5;
   localparam int OE_USB  = 6;
   localparam int OE_W    = 7;

   typedef struct packed {
      logic slow;
      logic test;
      logic core_en;
      logic usb_en;
   } mode_t;

   // code = {speed strap, select[1], select[0]}
   function automatic mode_t decode(input logic [2:0] code);
      mode_t m;
      m = '0;
      unique case (code[1:0])
         2'b00: begin
            m.test    = code[2];
            m.core_en = code[2];
            m.usb_en  = code[2];
         end
         2'b01: ;
         2'b10: begin
            m.slow    = ~code[2];
            m.core_en = 1'b1;
         end
         default: begin
            m.slow    = ~code[2];
            m.core_en = 1'b1;
            m.usb_en  = 1'b1;
         end
      endcase
      return m;
   endfunction

   function automatic int div_fast(input int br);
      case (br)
         BR_CPU:  return 2;
         BR_HALF: return 4;
         BR_F66:  return 4;
         BR_BUS:  return 8;
         default: return 16;
      endcase
   endfunction

   function automatic int div_slow(input int br);
      case (br)
         BR_CPU:  return 2;
         BR_HALF: return 4;
         BR_F66:  return 3;
         BR_BUS:  return 6;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sel_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("sel_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) chain[s] <= '0;
            else       chain[s] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk_i) begin
            if (rst_i) chain[s] <= '0;
            else       chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
   import clk_tree_pkg::*;
#(
   parameter int FRAME_FAST = 16,
   parameter int FRAME_SLOW = 12,
   parameter int CW         = $clog2(FRAME_FAST > FRAME_SLOW ? FRAME_FAST : FRAME_SLOW)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [2:0]    code_s_i,
   output logic [CW-1:0] cnt_nxt_o,
   output mode_t         mode_o,
   output mode_t         mode_nxt_o
);

   localparam logic [CW-1:0] LAST_F = CW'(FRAME_FAST - 1);
   localparam logic [CW-1:0] LAST_S = CW'(FRAME_SLOW - 1);

   if (FRAME_FAST < 2 || FRAME_SLOW < 2) begin : g_bad_frame
      $error("mode_ctrl: frames must be at least 2 cycles");
   end
   if ((1 << CW) < FRAME_FAST || (1 << CW) < FRAME_SLOW) begin : g_bad_cw
      $error("mode_ctrl: CW too narrow for the frame length");
   end

   logic [2:0]    act_code;
   logic [2:0]    code_nxt;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last;
   logic          at_wrap;

   assign mode_o     = decode(act_code);
   assign last       = mode_o.slow ? LAST_S : LAST_F;
   assign at_wrap    = (cnt == last);
   assign code_nxt   = at_wrap ? code_s_i : act_code;
   assign cnt_nxt_o  = at_wrap ? '0 : cnt + 1'b1;
   assign mode_nxt_o = decode(code_nxt);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         act_code <= 3'b000;
         cnt      <= LAST_F;
      end else begin
         act_code <= code_nxt;
         cnt      <= cnt_nxt_o;
      end
   end

   // R8: a pending code never lands in the middle of a frame
   p_frame_switch_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!at_wrap) |=> $stable(act_code));

   // R4: the frame counter never leaves the range of the active plan
   p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt <= last);

endmodule

// File: rtl/clk_branch.sv
module clk_branch #(
   parameter int DIV_FAST = 4,
   parameter int DIV_SLOW = 3,
   parameter int CW       = 4
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [CW-1:0] cnt_nxt_i,
   input  logic          slow_nxt_i,
   output logic          lvl_o
);

   localparam int HI_F = DIV_FAST / 2;
   localparam int HI_S = DIV_SLOW / 2;

   if (DIV_FAST < 2 || DIV_FAST % 2 != 0) begin : g_bad_fast
      $error("clk_branch: DIV_FAST must be even and at least 2");
   end
   if (DIV_SLOW < 2) begin : g_bad_slow
      $error("clk_branch: DIV_SLOW must be at least 2");
   end

   logic pos_hi;
   logic pos_q;
   logic slow_q;

   assign pos_hi = slow_nxt_i ? ((int'(cnt_nxt_i) % DIV_SLOW) < HI_S)
                              : ((int'(cnt_nxt_i) % DIV_FAST) < HI_F);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pos_q  <= 1'b0;
         slow_q <= 1'b0;
      end else begin
         pos_q  <= pos_hi;
         slow_q <= slow_nxt_i;
      end
   end

   if (DIV_SLOW % 2 == 1) begin : g_odd
      // falling-edge copy stretches the high phase by half a master cycle
      logic neg_q;
      always_ff @(negedge clk_i) begin
         if (rst_i) neg_q <= 1'b0;
         else       neg_q <= pos_q;
      end
      assign lvl_o = pos_q | (neg_q & slow_q);
   end else begin : g_even
      assign lvl_o = pos_q;
   end

endmodule

// File: rtl/clk_tree_div.sv
module clk_tree_div
   import clk_tree_pkg::*;
#(
   parameter int FRAME_FAST  = 16,
   parameter int FRAME_SLOW  = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            spd_sel_i,
   input  logic [1:0]      sel_i,
   input  logic            ref_i,
   input  logic            usb_i,
   output logic            cpu_o,
   output logic            cpu_half_o,
   output logic            fix66_o,
   output logic            bus_o,
   output logic            irq_o,
   output logic            ref_o,
   output logic            usb_o,
   output logic [OE_W-1:0] out_en_o
);

   localparam int CW = $clog2(FRAME_FAST > FRAME_SLOW ? FRAME_FAST : FRAME_SLOW);

   logic [2:0]        code_s;
   logic [CW-1:0]     cnt_nxt;
   mode_t             mode_q;
   mode_t             mode_nxt;
   logic [NUM_BR-1:0] lvl;

   sel_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   ({spd_sel_i, sel_i}),
      .q_o   (code_s)
   );

   mode_ctrl #(.FRAME_FAST(FRAME_FAST), .FRAME_SLOW(FRAME_SLOW), .CW(CW)) u_ctrl (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .code_s_i   (code_s),
      .cnt_nxt_o  (cnt_nxt),
      .mode_o     (mode_q),
      .mode_nxt_o (mode_nxt)
   );

   for (genvar b = 0; b < NUM_BR; b++) begin : g_br
      if (FRAME_FAST % div_fast(b) != 0 || FRAME_SLOW % div_slow(b) != 0) begin : g_bad_ratio
         $error("clk_tree_div: frame length is not a multiple of a branch ratio");
      end
      clk_branch #(.DIV_FAST(div_fast(b)), .DIV_SLOW(div_slow(b)), .CW(CW)) u_br (
         .clk_i      (clk_i),
         .rst_i      (rst_i),
         .cnt_nxt_i  (cnt_nxt),
         .slow_nxt_i (mode_nxt.slow),
         .lvl_o      (lvl[b])
      );
   end

   assign cpu_o      = lvl[BR_CPU];
   assign cpu_half_o = lvl[BR_HALF];
   assign fix66_o    = lvl[BR_F66];
   assign bus_o      = lvl[BR_BUS];
   assign irq_o      = lvl[BR_IRQ];

   assign ref_o = mode_q.test ? clk_i : ref_i;
   assign usb_o = mode_q.test ? lvl[BR_CPU] : usb_i;

   assign out_en_o = {mode_q.usb_en, {(OE_W-1){mode_q.core_en}}};

   // R4: bus clock never rises ahead of the 66 MHz clock
   p_bus_after_f66_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(bus_o) |-> $rose(fix66_o));

   // R4: interrupt clock rises only together with the processor clock
   p_irq_after_cpu_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(irq_o) |-> $rose(cpu_o));

   // R4: half-rate clock rises only together with the processor clock
   p_half_after_cpu_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(cpu_half_o) |-> $rose(cpu_o));

   // R8: outputs are enabled only on a frame-start rising edge
   p_enable_on_frame_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(|out_en_o) |-> $rose(irq_o));

endmodule

// File: tb/tb_clk_tree_div.sv
module tb_clk_tree_div;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       spd_sel;
   logic [1:0] sel;
   logic       ref_in;
   logic       usb_in;
   logic       cpu_o, cpu_half_o, fix66_o, bus_o, irq_o, ref_o, usb_o;
   logic [6:0] out_en_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   clk_tree_div dut (
      .clk_i      (clk),
      .rst_i      (rst),
      .spd_sel_i  (spd_sel),
      .sel_i      (sel),
      .ref_i      (ref_in),
      .usb_i      (usb_in),
      .cpu_o      (cpu_o),
      .cpu_half_o (cpu_half_o),
      .fix66_o    (fix66_o),
      .bus_o      (bus_o),
      .irq_o      (irq_o),
      .ref_o      (ref_o),
      .usb_o      (usb_o),
      .out_en_o   (out_en_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [6:0] exp_oe(input logic [2:0] c);
      if (c == 3'b100) return 7'h7F;
      if (c[1:0] == 2'b11) return 7'h7F;
      if (c[1:0] == 2'b10) return 7'h3F;
      return 7'h00;
   endfunction

   function automatic bit exp_slow(input logic [2:0] c);
      return (c[1] == 1'b1) && (c[2] == 1'b0);
   endfunction

   function automatic int ratio(input int br, input bit slow);
      int fr [5] = '{2, 4, 4, 8, 16};
      int sr [5] = '{2, 4, 3, 6, 12};
      return slow ? sr[br] : fr[br];
   endfunction

   function automatic bit exp_lvl(input int h, input int n);
      return (h % (2 * n)) < n;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] c);
      @(posedge clk); #2;
      {spd_sel, sel} = c;
      repeat (40) @(posedge clk);
      #2;
   endtask

   task automatic check_waves(input logic [2:0] c);
      bit   slow;
      bit   test;
      bit   prev;
      bit   found;
      int   bad [5];
      int   bad_ref;
      int   bad_usb;
      int   frame;
      logic [4:0] v;
      slow  = exp_slow(c);
      test  = (c == 3'b100);
      frame = slow ? 12 : 16;
      found = 0;
      prev  = 1'b1;
      bad_ref = 0;
      bad_usb = 0;
      for (int i = 0; i < 5; i++) bad[i] = 0;
      for (int k = 0; k < 40 && !found; k++) begin
         @(posedge clk); #2;
         if (irq_o && !prev) found = 1;
         prev = irq_o;
      end
      check(found, "R4", "frame start not seen", 0, 1);
      for (int cyc = 0; cyc < 2 * frame; cyc++) begin
         for (int half = 0; half < 2; half++) begin
            int h;
            h = 2 * cyc + half;
            v = {irq_o, bus_o, fix66_o, cpu_half_o, cpu_o};
            for (int b = 0; b < 5; b++)
               if (v[b] !== exp_lvl(h, ratio(b, slow))) bad[b]++;
            if (test) begin
               if (ref_o !== (half == 0)) bad_ref++;
               if (usb_o !== exp_lvl(h, 2)) bad_usb++;
            end
            if (half == 0) #5;
         end
         @(posedge clk); #2;
      end
      if (slow) begin
         check(bad[0] == 0, "R2", "cpu period 2", bad[0], 0);
         check(bad[1] == 0, "R2", "half period 4", bad[1], 0);
         check(bad[2] == 0, "R3", "f66 period 3 half-cycle duty", bad[2], 0);
         check(bad[3] == 0, "R2", "bus period 6", bad[3], 0);
         check(bad[4] == 0, "R2", "irq period 12", bad[4], 0);
      end else begin
         check(bad[0] == 0, "R1", "cpu period 2", bad[0], 0);
         check(bad[1] == 0, "R1", "half period 4", bad[1], 0);
         check(bad[2] == 0, "R1", "f66 period 4", bad[2], 0);
         check(bad[3] == 0, "R1", "bus period 8", bad[3], 0);
         check(bad[4] == 0, "R1", "irq period 16", bad[4], 0);
      end
      if (test) begin
         check(bad_ref == 0, "R6", "ref follows test clock", bad_ref, 0);
         check(bad_usb == 0, "R6", "usb is test clock / 2", bad_usb, 0);
      end
   endtask

   task automatic check_pass(input logic [2:0] c);
      for (int k = 0; k < 4; k++) begin
         ref_in = 1'($urandom_range(0, 1));
         usb_in = 1'($urandom_range(0, 1));
         #1;
         check(ref_o === ref_in, "R7", "ref_o passes ref_i", ref_o, ref_in);
         check(usb_o === usb_in, "R7", "usb_o passes usb_i", usb_o, usb_in);
      end
   endtask

   task automatic run_code(input logic [2:0] c);
      apply(c);
      if (exp_oe(c) == 7'h00)
         check(out_en_o === 7'h00, "R5", "disabled code enables", out_en_o, 0);
      else if (c == 3'b100)
         check(out_en_o === 7'h7F, "R6", "test mode enables", out_en_o, 7'h7F);
      else
         check(out_en_o === exp_oe(c), "R7", "normal enables", out_en_o, exp_oe(c));
      if (c != 3'b100) check_pass(c);
      if (exp_oe(c) != 7'h00) check_waves(c);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] codes [8] = '{3'b111, 3'b011, 3'b100, 3'b110,
                                3'b010, 3'b000, 3'b001, 3'b101};
      int n;
      bit ok;
      void'($urandom(32'd1234));
      rst = 1'b1; spd_sel = 1'b1; sel = 2'b11; ref_in = 1'b0; usb_in = 1'b0;
      repeat (6) @(posedge clk);
      #2;
      check(out_en_o === 7'h00, "R9", "reset enables", out_en_o, 0);
      // hold the disabled code, then release reset
      spd_sel = 1'b0; sel = 2'b00;
      rst = 1'b0;
      repeat (40) @(posedge clk);
      #2;
      check(out_en_o === 7'h00, "R5", "code 000 enables", out_en_o, 0);

      // R8: disabled -> full normal, measure adoption edge and alignment
      {spd_sel, sel} = 3'b111;
      n = 0;
      ok = 0;
      for (int k = 0; k < 40 && !ok; k++) begin
         @(posedge clk); #2;
         n++;
         if (out_en_o != 7'h00) ok = 1;
      end
      check(ok && n >= 3, "R8", "adoption too early", n, 3);
      check(n <= 19, "R8", "adoption later than one frame", n, 19);
      check({irq_o, bus_o, fix66_o, cpu_half_o, cpu_o} === 5'h1F, "R8",
            "branches aligned at switch", {irq_o, bus_o, fix66_o, cpu_half_o, cpu_o}, 5'h1F);

      // directed pass over every code
      for (int i = 0; i < 8; i++) run_code(codes[i]);
      // constrained random sequence
      for (int i = 0; i < 12; i++) run_code(codes[$urandom_range(0, 7)]);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule